// File: doc/BRIEF.md
# SPI Register Access Frame Interface

This block is a serial slave that receives fixed 24-bit command frames over a four-wire serial link and turns each one into a write to, or a read selection of, a small file of 16-bit registers. The file holds one command register, one monitor-select register, four channel data registers, four offset-trim registers and four gain-trim registers. Every register is also driven out in parallel to the downstream converter logic. Self-clearing command bits never stay set. They leave the block as one-cycle strobes.

The serial pins are sampled by the system clock. Inbound data is taken on the falling edge of the serial clock. The outbound bit changes on the rising edge. A read frame only selects a register. The selected register is shifted out during the frame that follows the read. A frame takes effect only if chip select returns high after exactly 24 serial clocks.

The frame state machine has four states. `ST_IDLE` waits for chip select to fall. `ST_SHIFT` counts and shifts bits. `ST_OVER` holds an over-long frame until chip select rises. `ST_COMMIT` is the single cycle in which a complete frame acts. The transitions are:
- IDLE→SHIFT on the chip-select fall.
- SHIFT→COMMIT on a chip-select rise with exactly 24 bits received.
- SHIFT→IDLE on a chip-select rise with any other bit count.
- SHIFT→OVER when a falling serial clock edge arrives with 24 bits already held.
- OVER→IDLE on the chip-select rise.
- COMMIT→IDLE unconditionally.

Top module: `spi_reg_access`

## Requirements
- R1: A frame carries R/W in bit 23, a 4-bit address in bits 19:16 and data in bits 15:0, sent MSB first with one bit per falling serial clock edge. With R/W=0 and exactly 24 bits, the addressed register is written after chip select rises.
- R2: A frame with any bit count other than 24 (for example 23 or 25) changes no register and no read selection.
- R3: A frame with R/W=1 selects its address for read-back. During the next frame, SDO carries 8 zero bits followed by that register's 16 bits, MSB first. Each bit appears after a rising serial clock edge. After reset, address 0 is selected.
- R4: After reset, the command register reads 033Ch and all other registers read 0000h. Both strobes are low and the output enable is low.
- R5: Reserved bits are dropped on write and read back as 0:
  - command register: the stored mask is 9BBCh;
  - channel data registers: bits 15:4 are kept;
  - offset registers: bits 8:0 are kept;
  - gain registers: bits 7:0 are kept.
- R6: A write to address 2 or 3 changes nothing. A read-back of address 2 or 3 returns 0000h.
- R7: `sdo_oe` is high only while chip select is low and command bit 7 is 0. While `sdo_oe` is low, `sdo` is 0.
- R8: Command bit 6 has no effect when written and always reads 0.
- R9: Monitor bits 15:11 are a one-hot select. `mon_sel` bit 0 is the auxiliary input and bits 1 to 4 are channels 0 to 3. `mon_en` is high when any select bit is set. A write that sets more than one of these bits is ignored.
- R10: Writing command bit 14 as 1 raises `load_pulse` for exactly one clock cycle. The bit reads back 0.
- R11: Writing command bit 13 as 1 raises `reset_pulse` for exactly one cycle and returns every register to its reset value. The bit reads back 0.
- R12: `cmd_reg`, `mon_reg`, `chan_data`, `offset_trim` and `gain_trim` present the stored register values. Channel n occupies slice n of each flattened bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| cmd_reg | output | 16 | Command register contents |
| mon_reg | output | 16 | Monitor register contents |
| mon_sel | output | 5 | One-hot monitor select: aux, ch0..ch3 |
| mon_en | output | 1 | Monitor active |
| chan_data | output | 48 | Four 12-bit channel data words |
| offset_trim | output | 36 | Four 9-bit offset trims |
| gain_trim | output | 32 | Four 8-bit gain trims |
| load_pulse | output | 1 | One-cycle load-all strobe |
| reset_pulse | output | 1 | One-cycle soft reset strobe |

## Verification
The assertions assume that the serial pins are slow compared with the system clock. Each serial clock phase must last several system cycles, SDI must be stable around each falling edge, and chip select must stay high for more than one cycle between frames so that no frame starts during the commit cycle. The stimulus holds each serial clock phase for six system cycles, changes SDI together with the rising edge, and leaves ten idle cycles after each frame. This keeps every edge distinct after the synchronizer and keeps the one-hot, single-cycle-strobe and reserved-address properties within their stated premises.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int FRAME_W     = 24;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 4;
    localparam int NUM_CH      = 4;
    localparam int CH_W        = 12;
    localparam int OFS_W       = 9;
    localparam int GAIN_W      = 8;
    localparam int CNT_W       = $clog2(FRAME_W + 2);
    localparam int MON_LO      = 11;
    localparam int MON_W       = 5;

    localparam int ADR_CMD      = 0;
    localparam int ADR_MON      = 1;
    localparam int ADR_CH_BASE  = 4;
    localparam int ADR_OFS_BASE = 8;
    localparam int ADR_GN_BASE  = 12;

    localparam int BIT_LOAD    = 14;
    localparam int BIT_SRST    = 13;
    localparam int BIT_SDO_OFF = 7;

    localparam logic [DATA_W-1:0] CMD_MASK    = 16'h9BBC;
    localparam logic [DATA_W-1:0] MON_MASK    = 16'hF800;
    localparam logic [DATA_W-1:0] CMD_DEFAULT = 16'h033C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_OVER,
        ST_COMMIT
    } frame_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_end,
    output logic cs_active,
    output logic sdi_s
);
    logic [STAGES:0]   sclk_h;
    logic [STAGES:0]   cs_h;
    logic [STAGES-1:0] sdi_h;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_h <= '0;
            cs_h   <= '1;
            sdi_h  <= '0;
        end else begin
            sclk_h <= {sclk_h[STAGES-1:0], sclk};
            cs_h   <= {cs_h[STAGES-1:0], cs_n};
            sdi_h  <= {sdi_h[STAGES-2:0], sdi};
        end
    end

    assign sclk_rise = sclk_h[STAGES-1] & ~sclk_h[STAGES];
    assign sclk_fall = ~sclk_h[STAGES-1] & sclk_h[STAGES];
    assign cs_start  = ~cs_h[STAGES-1] & cs_h[STAGES];
    assign cs_end    = cs_h[STAGES-1] & ~cs_h[STAGES];
    assign cs_active = ~cs_h[STAGES-1];
    assign sdi_s     = sdi_h[STAGES-1];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo_bit
);
    frame_state_t        state, state_nx;
    logic [CNT_W-1:0]    bit_cnt;
    logic [FRAME_W-1:0]  shift_in;
    logic [FRAME_W-1:0]  shift_out;
    logic                sdo_q;
    logic [ADDR_W-1:0]   rd_addr_q;
    logic                full;
    logic                unused_pad;

    assign full = (bit_cnt == CNT_W'(FRAME_W));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_start) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_end)                 state_nx = full ? ST_COMMIT : ST_IDLE;
                else if (sclk_fall && full) state_nx = ST_OVER;
            end
            ST_OVER:   if (cs_end) state_nx = ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
        endcase
    end

    // datapath driven by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shift_in  <= '0;
            shift_out <= '0;
            sdo_q     <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_start) begin
                        bit_cnt   <= '0;
                        shift_out <= FRAME_W'(rd_data);
                        sdo_q     <= 1'b0;
                    end
                end
                ST_SHIFT, ST_OVER: begin
                    if (state == ST_SHIFT && sclk_fall && !full) begin
                        shift_in <= {shift_in[FRAME_W-2:0], sdi_s};
                        bit_cnt  <= bit_cnt + 1'b1;
                    end
                    if (sclk_rise) begin
                        sdo_q     <= shift_out[FRAME_W-1];
                        shift_out <= {shift_out[FRAME_W-2:0], 1'b0};
                    end
                end
                ST_COMMIT: begin
                    if (shift_in[FRAME_W-1]) rd_addr_q <= shift_in[DATA_W+ADDR_W-1:DATA_W];
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_COMMIT) && !shift_in[FRAME_W-1];
        wr_addr = shift_in[DATA_W+ADDR_W-1:DATA_W];
        wr_data = shift_in[DATA_W-1:0];
        rd_addr = rd_addr_q;
        sdo_bit = sdo_q;
    end
    assign unused_pad = ^shift_in[FRAME_W-2:DATA_W+ADDR_W];

    p_commit_full_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> (bit_cnt == CNT_W'(FRAME_W)));
    p_over_never_commits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVER) |=> (state != ST_COMMIT));
    p_short_frame_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cs_end && bit_cnt != CNT_W'(FRAME_W)) |=> (state == ST_IDLE));
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_regs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        cmd_q,
    output logic [DATA_W-1:0]        mon_q,
    output logic [NUM_CH*CH_W-1:0]   chan_flat,
    output logic [NUM_CH*OFS_W-1:0]  ofs_flat,
    output logic [NUM_CH*GAIN_W-1:0] gain_flat,
    output logic                     load_pulse,
    output logic                     reset_pulse
);
    logic [CH_W-1:0]   ch_q   [NUM_CH];
    logic [OFS_W-1:0]  ofs_q  [NUM_CH];
    logic [GAIN_W-1:0] gain_q [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= CMD_DEFAULT;
            mon_q       <= '0;
            load_pulse  <= 1'b0;
            reset_pulse <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                ch_q[c]   <= '0;
                ofs_q[c]  <= '0;
                gain_q[c] <= '0;
            end
        end else begin
            load_pulse  <= 1'b0;
            reset_pulse <= 1'b0;
            if (wr_en) begin
                if (wr_addr == ADDR_W'(ADR_CMD)) begin
                    if (wr_data[BIT_SRST]) begin
                        cmd_q       <= CMD_DEFAULT;
                        mon_q       <= '0;
                        reset_pulse <= 1'b1;
                        for (int c = 0; c < NUM_CH; c++) begin
                            ch_q[c]   <= '0;
                            ofs_q[c]  <= '0;
                            gain_q[c] <= '0;
                        end
                    end else begin
                        cmd_q      <= wr_data & CMD_MASK;
                        load_pulse <= wr_data[BIT_LOAD];
                    end
                end else if (wr_addr == ADDR_W'(ADR_MON)) begin
                    if ($countones(wr_data[MON_LO+MON_W-1:MON_LO]) <= 1)
                        mon_q <= wr_data & MON_MASK;
                end
                for (int c = 0; c < NUM_CH; c++) begin
                    if (wr_addr == ADDR_W'(ADR_CH_BASE + c))
                        ch_q[c] <= wr_data[DATA_W-1:DATA_W-CH_W];
                    if (wr_addr == ADDR_W'(ADR_OFS_BASE + c))
                        ofs_q[c] <= wr_data[OFS_W-1:0];
                    if (wr_addr == ADDR_W'(ADR_GN_BASE + c))
                        gain_q[c] <= wr_data[GAIN_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_CMD)) rd_data = cmd_q;
        if (rd_addr == ADDR_W'(ADR_MON)) rd_data = mon_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(ADR_CH_BASE + c))
                rd_data = DATA_W'(ch_q[c]) << (DATA_W - CH_W);
            if (rd_addr == ADDR_W'(ADR_OFS_BASE + c))
                rd_data = DATA_W'(ofs_q[c]);
            if (rd_addr == ADDR_W'(ADR_GN_BASE + c))
                rd_data = DATA_W'(gain_q[c]);
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
        assign chan_flat[g*CH_W +: CH_W]     = ch_q[g];
        assign ofs_flat[g*OFS_W +: OFS_W]    = ofs_q[g];
        assign gain_flat[g*GAIN_W +: GAIN_W] = gain_q[g];
    end

    p_mon_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mon_q[MON_LO+MON_W-1:MON_LO]));
    p_load_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);
    p_soft_reset_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (cmd_q == CMD_DEFAULT && mon_q == '0 && chan_flat == '0));
    p_reserved_addr_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr inside {4'd2, 4'd3}) |=>
        ($stable(cmd_q) && $stable(mon_q) && $stable(chan_flat) && !load_pulse));
    p_nop_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ADR_CMD)) |-> !rd_data[6]);
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
    import spi_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     sdi,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic [DATA_W-1:0]        cmd_reg,
    output logic [DATA_W-1:0]        mon_reg,
    output logic [MON_W-1:0]         mon_sel,
    output logic                     mon_en,
    output logic [NUM_CH*CH_W-1:0]   chan_data,
    output logic [NUM_CH*OFS_W-1:0]  offset_trim,
    output logic [NUM_CH*GAIN_W-1:0] gain_trim,
    output logic                     load_pulse,
    output logic                     reset_pulse
);
    logic sclk_rise, sclk_fall, cs_start, cs_end, cs_active, sdi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              sdo_bit;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_start(cs_start),
        .cs_end(cs_end), .cs_active(cs_active), .sdi_s(sdi_s)
    );

    spi_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_end(cs_end), .sdi_s(sdi_s), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .sdo_bit(sdo_bit)
    );

    spi_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_q(cmd_reg), .mon_q(mon_reg), .chan_flat(chan_data),
        .ofs_flat(offset_trim), .gain_flat(gain_trim),
        .load_pulse(load_pulse), .reset_pulse(reset_pulse)
    );

    assign sdo_oe  = cs_active && !cmd_reg[BIT_SDO_OFF];
    assign sdo     = sdo_oe ? sdo_bit : 1'b0;
    assign mon_sel = mon_reg[MON_LO+MON_W-1:MON_LO];
    assign mon_en  = |mon_sel;

    p_sdo_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reg[BIT_SDO_OFF] |-> (!sdo_oe && !sdo));
    p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pulse && reset_pulse));
endmodule

// File: tb/spi_reg_access_test.sv
`timescale 1ns/1ps
module spi_reg_access_test;
    localparam int HALF = 6;
    localparam int NV   = 16;
    // {frame[23:0], expected SDO word of this frame[15:0]}
    localparam logic [39:0] VEC [NV] = '{
        {24'h840000, 16'h033C}, {24'h04ABCD, 16'h0000}, {24'h880000, 16'hABC0},
        {24'h08FFFF, 16'h0000}, {24'h0C1234, 16'h01FF}, {24'h8C0000, 16'h01FF},
        {24'h800000, 16'h0034}, {24'h02FFFF, 16'h033C}, {24'h820000, 16'h033C},
        {24'h011000, 16'h0000}, {24'h810000, 16'h0000}, {24'h870000, 16'h1000},
        {24'h000044, 16'h0000}, {24'h800000, 16'h0000}, {24'h830000, 16'h0004},
        {24'h850000, 16'h0000}
    };

    logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
    logic sdo, sdo_oe, mon_en, load_pulse, reset_pulse;
    logic [15:0] cmd_reg, mon_reg;
    logic [4:0]  mon_sel;
    logic [47:0] chan_data;
    logic [35:0] offset_trim;
    logic [31:0] gain_trim;
    int checks = 0, errors = 0, load_cnt = 0, reset_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_reg_access uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .cmd_reg(cmd_reg), .mon_reg(mon_reg),
        .mon_sel(mon_sel), .mon_en(mon_en), .chan_data(chan_data),
        .offset_trim(offset_trim), .gain_trim(gain_trim),
        .load_pulse(load_pulse), .reset_pulse(reset_pulse)
    );

    always @(posedge clk) begin
        if (load_pulse)  load_cnt++;
        if (reset_pulse) reset_cnt++;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] tx, input int nbits,
                        output logic [23:0] rx, output logic oe_seen);
        rx = '0;
        oe_seen = 1'b0;
        @(negedge clk) cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 24) ? tx[23-i] : 1'b0;
            sclk = 1;
            repeat (HALF) @(negedge clk);
            if (i < 24) rx[23-i] = sdo;
            oe_seen |= sdo_oe;
            sclk = 0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] rx;
        logic oe;
        int l0, r0;
        repeat (5) @(negedge clk);
        // R4: reset state
        check("R4 cmd default", cmd_reg, 16'h033C);
        check("R4 others zero", {mon_reg, chan_data, offset_trim, gain_trim}, '0);
        check("R4 strobes/oe low", {load_pulse, reset_pulse, sdo_oe}, 3'b000);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R1 R3 R5 R6 R8: table walk, readback comes one frame late
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][39:16], 24, rx, oe);
            check($sformatf("R1 R3 R5 R6 R8 vector %0d sdo", i), rx, {8'h00, VEC[i][15:0]});
            check($sformatf("R7 vector %0d oe during frame", i), oe, 1'b1);
        end

        // R12: parallel outputs
        check("R12 chan0", chan_data[11:0], 12'hABC);
        check("R12 offset0", offset_trim[8:0], 9'h1FF);
        check("R12 gain0", gain_trim[7:0], 8'h34);
        check("R12 cmd (R8 nop dropped)", cmd_reg, 16'h0004);
        check("R7 oe low when idle", sdo_oe, 1'b0);

        // R9: monitor one-hot
        check("R9 sel ch0", {mon_en, mon_sel}, 6'b1_00010);
        xfer(24'h011800, 24, rx, oe);
        check("R9 multi-hot write ignored", mon_reg, 16'h1000);
        xfer(24'h010800, 24, rx, oe);
        check("R9 sel aux", {mon_en, mon_sel}, 6'b1_00001);
        xfer(24'h010000, 24, rx, oe);
        check("R9 disabled", {mon_en, mon_sel}, 6'b0_00000);

        // R2: wrong bit counts discarded
        xfer(24'h055550, 23, rx, oe);
        check("R2 23-bit frame dropped", chan_data[23:12], 12'h000);
        xfer(24'h055550, 25, rx, oe);
        check("R2 25-bit frame dropped", chan_data[23:12], 12'h000);
        xfer(24'h875550, 23, rx, oe);
        xfer(24'h000000 | 24'h055550, 24, rx, oe);
        check("R2 short read did not move pointer", rx, 24'h000000);
        check("R1 full frame writes", chan_data[23:12], 12'h555);

        // R10: load strobe
        l0 = load_cnt;
        xfer(24'h004004, 24, rx, oe);
        check("R10 one pulse cycle", load_cnt - l0, 1);
        check("R10 bit reads 0", cmd_reg, 16'h0004);

        // R11: soft reset
        r0 = reset_cnt;
        xfer(24'h002000, 24, rx, oe);
        check("R11 one pulse cycle", reset_cnt - r0, 1);
        check("R11 cmd default", cmd_reg, 16'h033C);
        check("R11 regs cleared", {mon_reg, chan_data, offset_trim, gain_trim}, '0);

        // R7: SDO disable overrides chip select
        xfer(24'h000080, 24, rx, oe);
        xfer(24'h800000, 24, rx, oe);
        check("R7 disabled oe in frame", oe, 1'b0);
        check("R7 disabled sdo zero", rx, 24'h000000);
        xfer(24'h00033C, 24, rx, oe);
        check("R7 still disabled while rewriting", oe, 1'b0);
        xfer(24'h800000, 24, rx, oe);
        check("R7 re-enabled oe", oe, 1'b1);
        check("R3 readback after re-enable", rx, 24'h00033C);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule